// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that a processor drives through a small 32-bit register window. Software stages words in a transmit queue while the transfer-hold bit is set, then clears that bit to let the shift engine send the whole queue back to back. Each word goes out on the serial clock and data-out pins. The word captured from the data-in pin, or from the block's own data-out when loopback is on, lands in a receive queue that software drains through the receive data register.

The serial clock runs at a rate fixed by a build parameter (one half period lasts `CLK_DIV` system clocks). Software picks clock idle level, sampling phase, bit order and loopback. A per-slave, active-low select register drives the select pins. In manual mode the register drives them at all times. In automatic mode it drives them only while a word is shifting, and all pins are high otherwise. Single-cycle event pulses report that the transmit side has drained, that the transmit queue has reached half empty, that the receive queue has filled, and that a received word was lost to a full queue.

Top module: `spim_ctrl`

## Requirements
- R1: Register offsets are control 0x60, status 0x64, transmit data 0x68, receive data 0x6C and select 0x70. After reset, control reads 0x100 (only the hold bit set), status reads 0x05, all select pins are high, SCLK is low, and a receive-data read returns 0.
- R2: While control bit 8 (hold) is 1, queued words stay queued and SCLK does not toggle. Once the bit is cleared, the queue is shifted out word after word, with no more than one idle clock between words.
- R3: Status bit 3 (transmit full) is set once `DEPTH` words are queued. A transmit-data write made while the queue is full is dropped.
- R4: With control bit 0 (loopback) set, every transmitted word yields exactly one received word equal to it, in transmit order.
- R5: While no word is shifting, SCLK sits at the level of control bit 3 (idle level).
- R6: With loopback off, data-out carries each word MSB first, or LSB first when control bit 9 is 1. Data-in is captured in the same order. Control bit 4 (phase) selects whether data is sampled on the first or the second clock edge of each bit. All four idle-level/phase combinations work.
- R7: Writing 1 to control bit 5 empties the transmit queue, and writing 1 to bit 6 empties the receive queue. Both bits read back as 0.
- R8: With control bit 7 (manual select) set, the select pins equal the select register. With bit 7 clear, they equal the register only while a word is shifting, and all ones otherwise.
- R9: Shifting starts only when control bit 1 (enable) and bit 2 (master) are both 1 and the hold bit is 0.
- R10: Status bits are 0 receive empty, 1 receive full, 2 transmit drained (queue empty and engine idle), 3 transmit full, and 4 mode fault (always 0). Each event output is a one-cycle pulse. The drained event fires once when the last queued word finishes. The half event fires when the transmit count falls to `DEPTH`/2. The receive-full event fires when the receive queue fills. The overrun event fires for each word that arrives at a full receive queue, and that word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| evt_tx_empty | output | 1 | Last queued word finished |
| evt_tx_half | output | 1 | Transmit count fell to half depth |
| evt_rx_full | output | 1 | Receive queue became full |
| evt_rx_ovr | output | 1 | Received word dropped at full queue |

## Verification
Random loopback bursts of random length are run with random idle level, phase and bit order. They show whether words come back in order and unaltered, and whether SCLK returns to its idle level. A bench model of a slave that drives its own word back separates bit-order and sampling-phase faults, which loopback alone cannot expose. Directed cases fill the transmit queue past its depth and overfill the receive queue, which separates dropped writes, overrun discard and the event pulses. Further directed cases clear either enable bit, the hold bit or a queue, and toggle the select mode, to show that each gate acts alone.

// File: rtl/spim_pkg.sv
package spim_pkg;
    // Register byte offsets (software visible)
    localparam logic [7:0] OFS_CTRL = 8'h60;
    localparam logic [7:0] OFS_STAT = 8'h64;
    localparam logic [7:0] OFS_TXD  = 8'h68;
    localparam logic [7:0] OFS_RXD  = 8'h6C;
    localparam logic [7:0] OFS_SSEL = 8'h70;

    // Control bit positions
    localparam int CB_LOOP = 0;
    localparam int CB_EN   = 1;
    localparam int CB_MST  = 2;
    localparam int CB_POL  = 3;
    localparam int CB_PHA  = 4;
    localparam int CB_TCLR = 5;
    localparam int CB_RCLR = 6;
    localparam int CB_MAN  = 7;
    localparam int CB_HOLD = 8;
    localparam int CB_LSB  = 9;

    localparam int CTRL_W = 10;
    localparam logic [CTRL_W-1:0] CTRL_RST = 10'h100;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [W-1:0]                   pdata,
    input  logic                           pop,
    output logic [W-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fq_t;

    fq_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign count = q.cnt;
    assign head  = mem[q.rd];

    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (do_push) d.wr = (q.wr == PLAST) ? '0 : q.wr + 1'b1;
            if (do_pop)  d.rd = (q.rd == PLAST) ? '0 : q.rd + 1'b1;
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= pdata;
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int W   = 8,
    parameter int DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] word,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb,
    input  logic         miso_i,
    output logic         sclk,
    output logic         mosi,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_word
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int EW = $clog2(2 * W);
    localparam logic [CW-1:0] CMAX  = CW'(DIV - 1);
    localparam logic [EW-1:0] ELAST = EW'(2 * W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [EW-1:0] edg;
        logic          phase;
        logic [W-1:0]  sh;
        logic          samp;
        logic          done;
        logic [W-1:0]  rxw;
    } sh_t;

    sh_t q, d;

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    always_comb begin
        logic [W-1:0] fin;
        logic         lead;
        d      = q;
        d.done = 1'b0;
        fin    = '0;
        lead   = ~q.edg[0];
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.cnt   = '0;
                d.edg   = '0;
                d.phase = 1'b0;
                d.sh    = lsb ? flip(word) : word;
            end
        end else if (q.cnt == CMAX) begin
            d.cnt   = '0;
            d.phase = ~q.phase;
            d.edg   = q.edg + 1'b1;
            if (!cpha) begin
                // sample on leading edge, advance on trailing edge
                if (lead) d.samp = miso_i;
                else      d.sh   = {q.sh[W-2:0], q.samp};
                fin = {q.sh[W-2:0], q.samp};
            end else begin
                // advance on leading edge (not the first), sample on trailing
                if (lead) begin
                    if (q.edg != '0) d.sh = {q.sh[W-2:0], q.samp};
                end else begin
                    d.samp = miso_i;
                end
                fin = {q.sh[W-2:0], miso_i};
            end
            if (q.edg == ELAST) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.rxw  = lsb ? flip(fin) : fin;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = cpol ^ q.phase;
    assign mosi    = q.sh[W-1];
    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_word = q.rxw;
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int NUM_SS  = 4,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              evt_tx_empty,
    output logic              evt_tx_half,
    output logic              evt_rx_full,
    output logic              evt_rx_ovr
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [NUM_SS-1:0] ssr;
        logic              txh;
        logic              rxf;
    } reg_t;

    reg_t st_q, st_d;

    logic [CTRL_W-1:0] ctrl_q;
    logic [NUM_SS-1:0] ssr_q;
    logic              wr_ctrl, tx_clr, rx_clr, tx_push, rx_pop;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic              busy, done, start, run_ok, miso_int, tx_half;
    logic              unused_wdata;

    assign ctrl_q = st_q.ctrl;
    assign ssr_q  = st_q.ssr;
    assign unused_wdata = ^bus_wdata;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign tx_clr  = wr_ctrl && bus_wdata[CB_TCLR];
    assign rx_clr  = wr_ctrl && bus_wdata[CB_RCLR];
    assign tx_push = bus_wr && (bus_addr == OFS_TXD);
    assign rx_pop  = bus_rd && (bus_addr == OFS_RXD);

    assign run_ok   = ctrl_q[CB_EN] && ctrl_q[CB_MST] && !ctrl_q[CB_HOLD];
    assign start    = run_ok && !tx_empty && !busy && !tx_clr;
    assign miso_int = ctrl_q[CB_LOOP] ? mosi : miso;
    assign tx_half  = (tx_count <= HALF);

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl          = bus_wdata[CTRL_W-1:0];
            st_d.ctrl[CB_TCLR] = 1'b0;
            st_d.ctrl[CB_RCLR] = 1'b0;
        end
        if (bus_wr && (bus_addr == OFS_SSEL)) st_d.ssr = bus_wdata[NUM_SS-1:0];
        st_d.txh = tx_half;
        st_d.rxf = rx_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RST;
            st_q.ssr  <= '1;
            st_q.txh  <= 1'b1;
            st_q.rxf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
        .pdata(bus_wdata[DATA_W-1:0]), .pop(start), .head(tx_head),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(done),
        .pdata(rx_word), .pop(rx_pop), .head(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    spim_shift #(.W(DATA_W), .DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .word(tx_head),
        .cpol(ctrl_q[CB_POL]), .cpha(ctrl_q[CB_PHA]), .lsb(ctrl_q[CB_LSB]),
        .miso_i(miso_int), .sclk(sclk), .mosi(mosi), .busy(busy),
        .done(done), .rx_word(rx_word)
    );

    assign ss_n = (ctrl_q[CB_MAN] || busy) ? ssr_q : '1;

    assign evt_tx_empty = done && tx_empty;
    assign evt_tx_half  = tx_half && !st_q.txh;
    assign evt_rx_full  = rx_full && !st_q.rxf;
    assign evt_rx_ovr   = done && rx_full;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            OFS_STAT: bus_rdata[4:0] = {1'b0, tx_full, tx_empty && !busy,
                                        rx_full, rx_empty};
            OFS_RXD:  if (!rx_empty) bus_rdata[DATA_W-1:0] = rx_head;
            OFS_SSEL: bus_rdata[NUM_SS-1:0] = ssr_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
    import spim_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NUM_SS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [7:0]                 bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [CTRL_W-1:0]          ctrl,
    input logic [NUM_SS-1:0]          ss_n,
    input logic                       busy,
    input logic                       sclk,
    input logic [$clog2(DEPTH+1)-1:0] tx_count,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic                       evt_rx_ovr,
    input logic                       evt_tx_empty
);
    localparam int CW = $clog2(DEPTH + 1);

    // R2: hold with idle engine keeps the engine idle
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_HOLD] && !busy) |=> !busy);

    // R3: queue occupancy never exceeds depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    // R5: idle clock level follows the idle-level bit
    p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == ctrl[CB_POL]));

    // R7: transmit clear empties the queue on the next cycle
    p_tx_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[CB_TCLR]) |=> (tx_count == '0));

    // R8: manual select follows a register write
    p_ss_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SSEL && ctrl[CB_MAN])
        |=> (ss_n == $past(bus_wdata[NUM_SS-1:0])));

    // R10: overrun only at a full receive queue
    p_ovr_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_ovr |-> (rx_count == CW'(DEPTH)));

    // R10: drained event leaves the engine idle
    p_drain_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_empty |=> !busy);
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(DEPTH), .NUM_SS(NUM_SS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl(ctrl_q), .ss_n(ss_n), .busy(busy),
    .sclk(sclk), .tx_count(tx_count), .rx_count(rx_count),
    .evt_rx_ovr(evt_rx_ovr), .evt_tx_empty(evt_tx_empty)
);

// File: tb/spim_ctrl_bench.sv
`timescale 1ns/1ps
module spim_ctrl_bench;
    localparam int DW = 8, DEPTH = 16, NSS = 4, DIV = 2;
    localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                           A_RXD = 8'h6C, A_SS = 8'h70;
    localparam logic [31:0] K_LOOP = 32'h1, K_EN = 32'h2, K_MST = 32'h4,
        K_POL = 32'h8, K_PHA = 32'h10, K_TCLR = 32'h20, K_RCLR = 32'h40,
        K_MAN = 32'h80, K_HOLD = 32'h100, K_LSB = 32'h200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic sclk, mosi, miso;
    logic [NSS-1:0] ss_n;
    logic evt_tx_empty, evt_tx_half, evt_rx_full, evt_rx_ovr;

    always #2.5 clk = ~clk;

    spim_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .NUM_SS(NSS), .CLK_DIV(DIV)) u_spim_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
        .evt_tx_empty(evt_tx_empty), .evt_tx_half(evt_tx_half),
        .evt_rx_full(evt_rx_full), .evt_rx_ovr(evt_rx_ovr)
    );

    int checks = 0, errors = 0;
    int cyc = 0, n_edges = 0, n_txe = 0, n_half = 0, n_rxf = 0, n_ovr = 0;

    // slave model state
    logic cur_pol = 0, cur_pha = 0, cur_lsb = 0, sl_clr = 0;
    logic [DW-1:0] sl_tx = '0, sl_acc = '0, sl_last = '0;
    int sl_idx = 0;
    logic sl_prev = 0;

    always_comb miso = sl_tx[cur_lsb ? sl_idx : DW-1-sl_idx];

    always @(negedge clk) begin
        logic lead;
        cyc++;
        if (evt_tx_empty) n_txe++;
        if (evt_tx_half)  n_half++;
        if (evt_rx_full)  n_rxf++;
        if (evt_rx_ovr)   n_ovr++;
        if (sl_clr) begin
            sl_idx = 0;
        end else if (sclk !== sl_prev) begin
            n_edges++;
            lead = (sclk != cur_pol);
            if (cur_pha ? !lead : lead) begin
                sl_acc[cur_lsb ? sl_idx : DW-1-sl_idx] = mosi;
                if (sl_idx == DW-1) begin
                    sl_last = sl_acc;
                    sl_idx = 0;
                end else begin
                    sl_idx++;
                end
            end
        end
        sl_prev = sclk;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected below 150000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stat(input bit rxe, input bit rxf, input bit txe, input bit txf);
        return {27'b0, 1'b0, txf, txe, rxf, rxe};
    endfunction

    function automatic logic [31:0] cw(input bit loop, input bit pol, input bit pha,
                                       input bit lsb, input bit man, input bit hold);
        return K_EN | K_MST | (loop ? K_LOOP : 0) | (pol ? K_POL : 0) | (pha ? K_PHA : 0)
             | (lsb ? K_LSB : 0) | (man ? K_MAN : 0) | (hold ? K_HOLD : 0);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req, output int took);
        logic [31:0] s;
        int c0;
        bit ok;
        c0 = cyc; ok = 0; took = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(A_STAT, s);
            if (s[2]) begin ok = 1; break; end
        end
        took = cyc - c0;
        if (!ok) chk({req, " drain timeout"}, 32'd0, 32'd1);
    endtask

    task automatic slave_reset();
        @(posedge clk); sl_clr = 1'b1;
        @(posedge clk); sl_clr = 1'b0;
        @(negedge clk);
    endtask

    logic [DW-1:0] words [0:DEPTH+1];
    logic [31:0] v;
    int took, e0, t0, h0, f0, o0;

    initial begin
        void'($urandom(32'd1729));
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h100);
        rd(A_STAT, v); chk("R1 status", v, stat(1, 0, 1, 0));
        chk("R1 ss_n", 32'(ss_n), 32'hF);
        chk("R1 sclk", 32'(sclk), 0);
        rd(A_RXD, v); chk("R1 empty read", v, 0);

        // R2 / R8 manual select / R4
        wr(A_CTRL, cw(1, 0, 0, 0, 1, 1));
        wr(A_SS, 32'hE);
        idle(1); chk("R8 manual ss_n", 32'(ss_n), 32'hE);
        words[0] = 8'hA5; words[1] = 8'h3C; words[2] = 8'h81;
        for (int i = 0; i < 3; i++) wr(A_TXD, 32'(words[i]));
        e0 = n_edges;
        idle(50);
        chk("R2 no sclk while held", n_edges - e0, 0);
        rd(A_STAT, v); chk("R2 queued status", v, stat(1, 0, 0, 0));
        wr(A_CTRL, cw(1, 0, 0, 0, 1, 0));
        drain("R2", took);
        chk("R2 back-to-back time", 32'(took <= 3 * (2 * DW * DIV + 3) + 8), 1);
        chk("R2 edge count", n_edges - e0, 3 * 2 * DW);
        for (int i = 0; i < 3; i++) begin
            rd(A_RXD, v); chk("R4 loop word", v, 32'(words[i]));
        end
        rd(A_STAT, v); chk("R4 rx empty after", v, stat(1, 0, 1, 0));

        // R4 / R5 random loopback bursts
        for (int it = 0; it < 24; it++) begin
            bit p, h, l;
            int n;
            p = 1'($urandom); h = 1'($urandom); l = 1'($urandom);
            n = 1 + int'($urandom % DEPTH);
            wr(A_CTRL, cw(1, p, h, l, 1, 1));
            for (int i = 0; i < n; i++) begin
                words[i] = DW'($urandom);
                wr(A_TXD, 32'(words[i]));
            end
            t0 = n_txe;
            wr(A_CTRL, cw(1, p, h, l, 1, 0));
            drain("R4", took);
            chk("R5 idle level", 32'(sclk), 32'(p));
            chk("R10 drained event once", n_txe - t0, 1);
            for (int i = 0; i < n; i++) begin
                rd(A_RXD, v); chk("R4 random loop word", v, 32'(words[i]));
            end
        end

        // R6 external slave, all modes and both orders
        for (int it = 0; it < 16; it++) begin
            bit p, h, l;
            logic [DW-1:0] tw;
            p = it[0]; h = it[1]; l = it[2];
            wr(A_CTRL, cw(0, p, h, l, 1, 1));
            @(posedge clk);
            cur_pol = p; cur_pha = h; cur_lsb = l; sl_tx = DW'($urandom);
            slave_reset();
            tw = DW'($urandom);
            wr(A_TXD, 32'(tw));
            wr(A_CTRL, cw(0, p, h, l, 1, 0));
            drain("R6", took);
            rd(A_RXD, v); chk("R6 captured slave word", v, 32'(sl_tx));
            chk("R6 slave saw tx word", 32'(sl_last), 32'(tw));
        end

        // R8 automatic select
        wr(A_CTRL, cw(1, 0, 0, 0, 0, 1));
        wr(A_SS, 32'hB);
        wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
        idle(2); chk("R8 auto idle ss_n", 32'(ss_n), 32'hF);
        wr(A_CTRL, cw(1, 0, 0, 0, 0, 0));
        idle(2); chk("R8 auto active ss_n", 32'(ss_n), 32'hB);
        drain("R8", took);
        chk("R8 auto after ss_n", 32'(ss_n), 32'hF);
        rd(A_RXD, v); chk("R8 word0", v, 32'h11);
        rd(A_RXD, v); chk("R8 word1", v, 32'h22);

        // R9 enable and master both required
        wr(A_CTRL, K_MST | K_LOOP | K_MAN);
        wr(A_TXD, 32'h5A);
        e0 = n_edges;
        idle(40);
        chk("R9 no enable edges", n_edges - e0, 0);
        rd(A_STAT, v); chk("R9 no enable status", v, stat(1, 0, 0, 0));
        wr(A_CTRL, K_EN | K_LOOP | K_MAN);
        idle(40);
        chk("R9 no master edges", n_edges - e0, 0);
        rd(A_STAT, v); chk("R9 no master status", v, stat(1, 0, 0, 0));
        wr(A_CTRL, K_EN | K_MST | K_LOOP | K_MAN);
        drain("R9", took);
        rd(A_RXD, v); chk("R9 word", v, 32'h5A);

        // R3 / R10 full transmit queue, overrun
        wr(A_CTRL, cw(1, 0, 1, 1, 1, 1));
        for (int i = 0; i < DEPTH; i++) begin
            words[i] = DW'($urandom);
            wr(A_TXD, 32'(words[i]));
        end
        rd(A_STAT, v); chk("R3 tx full status", v, stat(1, 0, 0, 1));
        wr(A_TXD, 32'hEE);
        h0 = n_half; f0 = n_rxf; o0 = n_ovr; t0 = n_txe;
        wr(A_CTRL, cw(1, 0, 1, 1, 1, 0));
        drain("R3", took);
        rd(A_STAT, v); chk("R10 rx full status", v, stat(0, 1, 1, 0));
        chk("R10 half event", n_half - h0, 1);
        chk("R10 rx full event", n_rxf - f0, 1);
        chk("R10 drained event", n_txe - t0, 1);
        chk("R10 no overrun yet", n_ovr - o0, 0);
        wr(A_CTRL, cw(1, 0, 1, 1, 1, 1));
        wr(A_TXD, 32'h77); wr(A_TXD, 32'h88);
        wr(A_CTRL, cw(1, 0, 1, 1, 1, 0));
        drain("R10", took);
        chk("R10 overrun events", n_ovr - o0, 2);
        for (int i = 0; i < DEPTH; i++) begin
            rd(A_RXD, v); chk("R3 R10 kept word", v, 32'(words[i]));
        end
        rd(A_STAT, v); chk("R3 dropped extra", v, stat(1, 0, 1, 0));

        // R7 queue clears
        wr(A_CTRL, cw(1, 0, 0, 0, 1, 1));
        wr(A_TXD, 32'h01); wr(A_TXD, 32'h02); wr(A_TXD, 32'h03);
        rd(A_STAT, v); chk("R7 tx queued", v, stat(1, 0, 0, 0));
        wr(A_CTRL, cw(1, 0, 0, 0, 1, 1) | K_TCLR);
        rd(A_STAT, v); chk("R7 tx cleared", v, stat(1, 0, 1, 0));
        rd(A_CTRL, v); chk("R7 clear bits read 0", v, cw(1, 0, 0, 0, 1, 1));
        e0 = n_edges;
        wr(A_CTRL, cw(1, 0, 0, 0, 1, 0));
        idle(50);
        chk("R7 nothing shifted", n_edges - e0, 0);
        wr(A_CTRL, cw(1, 0, 0, 0, 1, 1));
        wr(A_TXD, 32'h44); wr(A_TXD, 32'h55);
        wr(A_CTRL, cw(1, 0, 0, 0, 1, 0));
        drain("R7", took);
        rd(A_STAT, v); chk("R7 rx holds words", v, stat(0, 0, 1, 0));
        wr(A_CTRL, cw(1, 0, 0, 0, 1, 0) | K_RCLR);
        rd(A_STAT, v); chk("R7 rx cleared", v, stat(1, 0, 1, 0));
        rd(A_RXD, v); chk("R7 rx read empty", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule